// File: doc/BRIEF.md
# Programmable Bus Waveform Sequencer

This block drives a parallel peripheral bus by stepping through waveform descriptors held in a small writable table. It does not use a fixed read/write state machine. The table holds four waveforms of eight intervals each. For every interval, the table gives a dwell time, a set of data and address actions, and the levels of six control lines. The host picks which waveform serves each of four transaction types: FIFO read, FIFO write, single read and single write.

A host first loads the table and a few configuration registers through a byte-wide register-write port. It then pulses a trigger together with a transaction type. The engine walks through intervals 0 to 6 and then returns to interval 7, the rest state. On the way it raises data-bus strobes, next-item pulses and address increments as the table directs. The host can cancel a running waveform at any time through an abort register.

The write port decodes its address in two regions:
- Addresses 0x00 to 0x7F reach the descriptor table. The address bits are {wave[1:0], row[1:0], interval[2:0]}. Row 0 is the dwell length, row 1 the opcode, row 2 the control-line pattern and row 3 a spare byte.
- Addresses 0x80 to 0x83 reach four registers: the waveform map at 0x80, the rest-state control pattern at 0x81, abort at 0x82 and a bus address preset at 0x83.

Top module: `bws_top`

## Requirements
- R1: After reset the engine rests in interval 7. `busy`, `done`, `data_drive`, `data_sample` and `bus_addr` are all 0. `ctl_out` is 0x3F, and the waveform map reads 0xE4.
- R2: After a trigger accepted at idle, interval i (0 to 6) lasts as many clocks as its length byte. A length of 0 counts as 1.
- R3: In intervals 0 to 6, `ctl_out` equals bits 5:0 of the interval's pattern byte. In interval 7 it equals bits 5:0 of the rest-state register (0x81).
- R4: When opcode bit 1 is set, `data_drive` is high for the write types (type 1 and type 3) and `data_sample` is high for the read types (type 0 and type 2). Both stay low in interval 7.
- R5: On the clock that leaves an interval, `bus_addr` increments by exactly one if opcode bit 3 is set. `data_next` pulses high on that last clock if opcode bit 2 is set. Writing 0x83 at idle presets `bus_addr`.
- R6: Transaction type t uses the waveform whose number is held in bits [2t+1:2t] of the waveform map (0x80).
- R7: A trigger that arrives while a waveform is running is ignored.
- R8: When interval 6 completes, the engine enters interval 7 with `done` high for exactly one clock, and `busy` drops.
- R9: Writing 0xFF to 0x82 sends the engine to interval 7 on the next clock. This raises no `done` and does not move `bus_addr`. Any other value written there has no effect.
- R10: Writes to the table, the map, the rest-state register and the address preset are dropped while `busy` is high.
- R11: `state_out` shows the current interval number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register/table write strobe |
| cfg_addr | input | 8 | Write address |
| cfg_wdata | input | 8 | Write data |
| trig | input | 1 | Start a transaction (taken only at idle) |
| trig_type | input | 2 | Transaction type: 0 FIFO read, 1 FIFO write, 2 single read, 3 single write |
| busy | output | 1 | Waveform in progress |
| done | output | 1 | One-clock pulse on normal completion |
| state_out | output | 3 | Current interval number |
| ctl_out | output | 6 | Control-line levels (bit 3 select, bit 4 read, bit 5 write, all active low) |
| bus_addr | output | ADDR_W | Bus address counter |
| data_drive | output | 1 | Drive the data bus this clock |
| data_sample | output | 1 | Sample the data bus this clock |
| data_next | output | 1 | Advance to the next data item |

## Verification
The bench sweeps every transaction type under two opposite waveform maps, using a table whose lengths include 0 and whose opcode and pattern bytes vary with both the waveform and the interval. A design that ignored the map would show the wrong patterns. A design that mishandled a zero length would hang in that interval or skip it. One run fires a retrigger and a set of configuration writes while the engine is busy. Leaking any of these would show up as a restart, a changed table on the rerun, or a wrong rest-state level. The abort test first writes a non-0xFF value, which must do nothing, and then aborts part-way through a waveform. A design that raised `done` or stepped the address on abort would fail there.

// File: rtl/bws_pkg.sv
`timescale 1ns/1ps
package bws_pkg;
    localparam int NUM_WAVES  = 4;
    localparam int NUM_IVL    = 8;
    localparam int NUM_ROWS   = 4;
    localparam int WAVE_BITS  = $clog2(NUM_WAVES);
    localparam int IVL_BITS   = $clog2(NUM_IVL);
    localparam int ROW_BITS   = $clog2(NUM_ROWS);
    localparam int TBL_BITS   = WAVE_BITS + ROW_BITS + IVL_BITS;
    localparam int TBL_DEPTH  = 1 << TBL_BITS;

    localparam logic [IVL_BITS-1:0] IVL_REST = IVL_BITS'(NUM_IVL - 1);
    localparam logic [IVL_BITS-1:0] IVL_LAST = IVL_BITS'(NUM_IVL - 2);

    localparam logic [7:0] REG_WMAP   = 8'h80;
    localparam logic [7:0] REG_REST   = 8'h81;
    localparam logic [7:0] REG_ABORT  = 8'h82;
    localparam logic [7:0] REG_APRE   = 8'h83;
    localparam logic [7:0] ABORT_CODE = 8'hFF;
    localparam logic [7:0] WMAP_RST   = 8'hE4;
    localparam logic [7:0] REST_RST   = 8'hFF;

    localparam int OP_DATA = 1;
    localparam int OP_NEXT = 2;
    localparam int OP_AINC = 3;

    typedef enum logic [ROW_BITS-1:0] {
        ROW_LEN   = 2'd0,
        ROW_OP    = 2'd1,
        ROW_PAT   = 2'd2,
        ROW_SPARE = 2'd3
    } row_e;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] op;
        logic [7:0] pat;
    } ivl_desc_t;

    function automatic logic [WAVE_BITS-1:0] wave_of(input logic [7:0] wmap,
                                                      input logic [1:0] ttype);
        return wmap[2*ttype +: 2];
    endfunction

    function automatic logic [7:0] dwell_of(input logic [7:0] len);
        return (len == 8'd0) ? 8'd1 : len;
    endfunction
endpackage

// File: rtl/bws_regs.sv
`timescale 1ns/1ps
module bws_regs
    import bws_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [7:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    input  logic                 eng_idle,
    input  logic [WAVE_BITS-1:0] rd_wave,
    input  logic [IVL_BITS-1:0]  rd_ivl,
    output ivl_desc_t            desc,
    output logic [7:0]           wmap,
    output logic [7:0]           rest_ctl,
    output logic                 abort_req,
    output logic                 apre_load,
    output logic [ADDR_W-1:0]    apre_val
);
    logic [7:0] tbl [TBL_DEPTH];
    logic       wr_ok;
    logic       tbl_hit;

    assign wr_ok     = cfg_we && eng_idle;
    assign tbl_hit   = (cfg_addr[7] == 1'b0);
    assign abort_req = cfg_we && (cfg_addr == REG_ABORT) && (cfg_wdata == ABORT_CODE);
    assign apre_load = wr_ok && (cfg_addr == REG_APRE);
    assign apre_val  = ADDR_W'(cfg_wdata);

    always_ff @(posedge clk) begin
        if (wr_ok && tbl_hit)
            tbl[cfg_addr[TBL_BITS-1:0]] <= cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wmap     <= WMAP_RST;
            rest_ctl <= REST_RST;
        end else if (wr_ok) begin
            if (cfg_addr == REG_WMAP) wmap     <= cfg_wdata;
            if (cfg_addr == REG_REST) rest_ctl <= cfg_wdata;
        end
    end

    always_comb begin
        desc.len = tbl[{rd_wave, ROW_LEN, rd_ivl}];
        desc.op  = tbl[{rd_wave, ROW_OP,  rd_ivl}];
        desc.pat = tbl[{rd_wave, ROW_PAT, rd_ivl}];
    end
endmodule

// File: rtl/bws_seq.sv
`timescale 1ns/1ps
module bws_seq
    import bws_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig,
    input  logic [1:0]           trig_type,
    input  logic [7:0]           wmap,
    input  logic [7:0]           cur_len,
    input  logic                 abort_req,
    output logic [IVL_BITS-1:0]  ivl,
    output logic [WAVE_BITS-1:0] wave,
    output logic [1:0]           ttype,
    output logic                 busy,
    output logic                 leave,
    output logic                 done
);
    logic [7:0] cnt;

    assign busy  = (ivl != IVL_REST);
    assign leave = busy && !abort_req && (cnt == dwell_of(cur_len) - 8'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl   <= IVL_REST;
            wave  <= '0;
            ttype <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort_req) begin
                ivl <= IVL_REST;
                cnt <= '0;
            end else if (!busy) begin
                if (trig) begin
                    ivl   <= '0;
                    wave  <= wave_of(wmap, trig_type);
                    ttype <= trig_type;
                    cnt   <= '0;
                end
            end else if (leave) begin
                cnt <= '0;
                ivl <= ivl + 1'b1;
                if (ivl == IVL_LAST) done <= 1'b1;
            end else begin
                cnt <= cnt + 8'd1;
            end
        end
    end
endmodule

// File: rtl/bws_addr.sv
`timescale 1ns/1ps
module bws_addr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= load_val;
        else if (step) addr <= addr + ADDR_W'(1);
    end
endmodule

// File: rtl/bws_top.sv
`timescale 1ns/1ps
module bws_top
    import bws_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              trig,
    input  logic [1:0]        trig_type,
    output logic              busy,
    output logic              done,
    output logic [2:0]        state_out,
    output logic [5:0]        ctl_out,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              data_drive,
    output logic              data_sample,
    output logic              data_next
);
    ivl_desc_t            desc;
    logic [7:0]           wmap;
    logic [7:0]           rest_ctl;
    logic                 abort_req;
    logic                 apre_load;
    logic [ADDR_W-1:0]    apre_val;
    logic [IVL_BITS-1:0]  ivl;
    logic [WAVE_BITS-1:0] wave;
    logic [1:0]           ttype;
    logic                 leave;
    logic                 is_write;

    bws_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .eng_idle(!busy), .rd_wave(wave), .rd_ivl(ivl),
        .desc(desc), .wmap(wmap), .rest_ctl(rest_ctl), .abort_req(abort_req),
        .apre_load(apre_load), .apre_val(apre_val)
    );

    bws_seq u_seq (
        .clk(clk), .rst(rst), .trig(trig), .trig_type(trig_type), .wmap(wmap),
        .cur_len(desc.len), .abort_req(abort_req), .ivl(ivl), .wave(wave),
        .ttype(ttype), .busy(busy), .leave(leave), .done(done)
    );

    bws_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .load(apre_load), .load_val(apre_val),
        .step(leave && desc.op[OP_AINC]), .addr(bus_addr)
    );

    assign is_write    = ttype[0];
    assign state_out   = ivl;
    assign ctl_out     = busy ? desc.pat[5:0] : rest_ctl[5:0];
    assign data_drive  = busy && desc.op[OP_DATA] && is_write;
    assign data_sample = busy && desc.op[OP_DATA] && !is_write;
    assign data_next   = leave && desc.op[OP_NEXT];
endmodule

// File: rtl/bws_chk.sv
`timescale 1ns/1ps
module bws_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic              busy,
    input logic              done,
    input logic [2:0]        state_out,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              data_drive,
    input logic              data_sample
);
    // R8: completion pulse lasts one clock
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: completion only arrives from interval 6 into rest
    a_r8_done_from_last: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_out == 3'd7) && ($past(state_out) == 3'd6) && !busy);

    // R7: a running waveform never restarts at interval 0
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_out != 3'd7) && (state_out != 3'd0) |=> (state_out != 3'd0));

    // R9: abort returns to rest without a completion pulse
    a_r9_abort: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 8'h82 && cfg_wdata == 8'hFF)
        |=> (state_out == 3'd7) && !done);

    // R5: address moves by at most one per clock while running
    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        busy |=> (bus_addr == $past(bus_addr)) || (bus_addr == $past(bus_addr) + ADDR_W'(1)));

    // R4: data bus quiet at rest, never both directions
    a_r4_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !(data_drive && data_sample) && ((state_out == 3'd7) -> !(data_drive || data_sample)));
endmodule

bind bws_top bws_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .state_out(state_out),
    .bus_addr(bus_addr), .data_drive(data_drive), .data_sample(data_sample)
);

// File: tb/bws_top_tb.sv
`timescale 1ns/1ps
module bws_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       trig = 1'b0;
    logic [1:0] trig_type = '0;
    logic       busy, done, data_drive, data_sample, data_next;
    logic [2:0] state_out;
    logic [5:0] ctl_out;
    logic [7:0] bus_addr;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;
    logic [7:0] lenm [4][8];
    logic [7:0] opm  [4][8];
    logic [7:0] patm [4][8];
    logic [7:0] exp_addr = '0;
    logic [5:0] exp_rest = 6'h3F;

    always #2.5 clk = ~clk;

    bws_top #(.ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .trig(trig), .trig_type(trig_type),
        .busy(busy), .done(done), .state_out(state_out), .ctl_out(ctl_out),
        .bus_addr(bus_addr), .data_drive(data_drive), .data_sample(data_sample),
        .data_next(data_next)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_tx(input int t, input logic [7:0] wmap, input bit poke);
        int w;
        int k;
        int dw;
        w = int'((wmap >> (2 * t)) & 8'd3);
        @(negedge clk);
        trig = 1'b1; trig_type = 2'(t);
        @(negedge clk);
        trig = 1'b0;
        k = 0;
        for (int i = 0; i < 7; i++) begin
            dw = (lenm[w][i] == 0) ? 1 : int'(lenm[w][i]);
            for (int c = 0; c < dw; c++) begin
                chk("R11 state", 32'(state_out), 32'(i));
                chk("R2 busy in interval", 32'(busy), 32'd1);
                chk("R3/R6 ctl pattern", 32'(ctl_out), 32'(patm[w][i][5:0]));
                chk("R4 drive", 32'(data_drive), 32'(opm[w][i][1] && (t % 2 == 1)));
                chk("R4 sample", 32'(data_sample), 32'(opm[w][i][1] && (t % 2 == 0)));
                chk("R5 addr", 32'(bus_addr), 32'(exp_addr));
                chk("R5 next", 32'(data_next), 32'((c == dw - 1) && opm[w][i][2]));
                chk("R8 no early done", 32'(done), 32'd0);
                if (poke) begin
                    // R7/R10: retrigger and config writes while busy
                    case (k)
                        0: begin cfg_we = 1; cfg_addr = 8'h81; cfg_wdata = 8'h00;
                                 trig = 1; trig_type = 2'((t + 1) % 4); end
                        1: begin cfg_we = 1; cfg_addr = 8'(w * 32 + 16 + 6); cfg_wdata = 8'h00;
                                 trig = 0; end
                        2: begin cfg_we = 1; cfg_addr = 8'h80; cfg_wdata = 8'h00; end
                        3: begin cfg_we = 1; cfg_addr = 8'h83; cfg_wdata = 8'h99; end
                        default: cfg_we = 0;
                    endcase
                end
                k++;
                @(negedge clk);
                if (c == dw - 1 && opm[w][i][3]) exp_addr = exp_addr + 8'd1;
            end
        end
        cfg_we = 0; trig = 0;
        chk("R8 done", 32'(done), 32'd1);
        chk("R8 rest state", 32'(state_out), 32'd7);
        chk("R8 busy low", 32'(busy), 32'd0);
        chk("R3 rest ctl", 32'(ctl_out), 32'(exp_rest));
        chk("R4 rest quiet", 32'({data_drive, data_sample}), 32'd0);
        chk("R5 addr end", 32'(bus_addr), 32'(exp_addr));
        @(negedge clk);
        chk("R8 done one clock", 32'(done), 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] saved;
        for (int w = 0; w < 4; w++)
            for (int i = 0; i < 8; i++) begin
                lenm[w][i] = 8'((w * 7 + i * 3) % 4);
                opm[w][i]  = 8'(((((i + w) % 3) == 0) ? 8 : 0) | ((i % 2) << 2) | (((i + w) % 2) << 1));
                patm[w][i] = 8'(8'hC0 | ((w * 13 + i * 5 + 1) & 63));
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 state", 32'(state_out), 32'd7);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 ctl", 32'(ctl_out), 32'h3F);
        chk("R1 addr", 32'(bus_addr), 32'd0);
        chk("R1 data", 32'({data_drive, data_sample, data_next}), 32'd0);

        for (int w = 0; w < 4; w++)
            for (int i = 0; i < 8; i++) begin
                wr(8'(w * 32 + i),      lenm[w][i]);
                wr(8'(w * 32 + 8 + i),  opm[w][i]);
                wr(8'(w * 32 + 16 + i), patm[w][i]);
                wr(8'(w * 32 + 24 + i), 8'h5A);
            end
        wr(8'h83, 8'h10);
        exp_addr = 8'h10;
        chk("R5 preset", 32'(bus_addr), 32'h10);

        // R6: default map then reversed map
        for (int t = 0; t < 4; t++) run_tx(t, 8'hE4, 0);
        wr(8'h80, 8'h1B);
        for (int t = 0; t < 4; t++) run_tx(t, 8'h1B, 0);

        // R7 / R10: busy writes and retrigger dropped
        run_tx(2, 8'h1B, 1);
        run_tx(2, 8'h1B, 0);

        // R3: rest-state register
        wr(8'h81, 8'hA5);
        exp_rest = 6'h25;
        chk("R3 rest reg", 32'(ctl_out), 32'h25);

        // R9: abort
        @(negedge clk);
        trig = 1; trig_type = 2'd0;
        @(negedge clk);
        trig = 0;
        @(negedge clk);
        wr(8'h82, 8'h55);
        chk("R9 non-abort value ignored", 32'(busy), 32'd1);
        saved = bus_addr;
        wr(8'h82, 8'hFF);
        chk("R9 abort state", 32'(state_out), 32'd7);
        chk("R9 abort busy", 32'(busy), 32'd0);
        chk("R9 abort no done", 32'(done), 32'd0);
        chk("R9 abort addr", 32'(bus_addr), 32'(saved));
        chk("R9 abort ctl", 32'(ctl_out), 32'h25);
        @(negedge clk);
        chk("R9 no late done", 32'(done), 32'd0);
        exp_addr = bus_addr;
        run_tx(1, 8'h1B, 0);

        finish_run();
    end
endmodule